// File: doc/BRIEF.md
# USB Endpoint Control Register Bank

This block keeps the per-endpoint configuration of a USB device controller: one small control register for each endpoint number, all with the same layout. Firmware programs and inspects the registers over a simple register bus with one cycle of read latency. The serial interface engine uses the same storage in two ways. It asks whether an incoming token may proceed, and it reports each STALL it sends so that a sticky flag is recorded for that endpoint.

For each token (SETUP, IN or OUT) the engine presents a token strobe, the token type and the endpoint number. In the same cycle the block answers with an accept flag and a handshake flag. Packet handling, buffer descriptors and the transceiver belong to other blocks.

Every register has five live bits, numbered from bit 0:

| Bit | Meaning |
|---|---|
| 0 | Stall flag |
| 1 | IN enable |
| 2 | OUT enable |
| 3 | Control disable (active low for SETUP) |
| 4 | Handshake enable |

Bits above 4 are not implemented. The token type encoding is 00 OUT, 01 IN, 10 SETUP and 11 reserved.

Top module: `usb_ep_ctl_bank`

## Requirements
- R1: After power-on reset (`rst_n` low) every implemented bit of every endpoint register is 0, so every address reads back 0x00.
- R2: Register bits 7 to 5 always read 0, and writing 1s to them has no effect.
- R3: A write with `reg_wr` high stores `reg_wdata[4:0]` into the register selected by `reg_addr` and touches no other endpoint. `reg_rdata` shows, one clock after an address is presented, the contents that address held before any write in that same cycle.
- R4: An OUT token (type 00) is accepted exactly when bit 2 of the addressed register is 1.
- R5: An IN token (type 01) is accepted exactly when bit 1 of the addressed register is 1.
- R6: A SETUP token (type 10) is accepted exactly when bits 2 and 1 are both 1 and bit 3 is 0. With bit 3 at 1, the endpoint still takes IN and OUT tokens but refuses SETUP.
- R7: `tok_handshake` is 1 exactly when the token is accepted and bit 4 of the addressed register is 1. With bit 4 at 0, no handshake is requested for any token.
- R8: A `stall_set` pulse sets bit 0 of the endpoint `stall_ep`. The bit stays set through any writes that leave bit 0 at 1, and is cleared only by a firmware write of 0 to bit 0 or by `sie_reset`.
- R9: When a `stall_set` pulse and a firmware write that clears bit 0 of the same endpoint happen in the same cycle, bit 0 ends up 1. The other bits still take the written value.
- R10: `sie_reset` clears bit 0 of every endpoint, overriding both a same-cycle stall pulse and a same-cycle write. Bits 4 to 1 are left unchanged, apart from any normal firmware write in that cycle.
- R11: Reserved token type 11 is never accepted. When `tok_valid` is 0, both `tok_accept` and `tok_handshake` are 0.
- R12: `tok_accept` and `tok_handshake` are combinational and valid in the same cycle as `tok_valid`. A register write takes effect on the token answer from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| sie_reset | input | 1 | Engine reset, clears all stall flags |
| reg_addr | input | ADDR_W (4) | Register bus address, selects the endpoint |
| reg_wdata | input | DATA_W (8) | Register bus write data |
| reg_wr | input | 1 | Register bus write strobe |
| reg_rdata | output | DATA_W (8) | Register bus read data, one cycle latency |
| stall_set | input | 1 | Engine reports a STALL sent on `stall_ep` |
| stall_ep | input | ADDR_W (4) | Endpoint that sent the STALL |
| tok_valid | input | 1 | Token strobe |
| tok_kind | input | 2 | Token type: 00 OUT, 01 IN, 10 SETUP, 11 reserved |
| tok_ep | input | ADDR_W (4) | Endpoint number of the token |
| tok_accept | output | 1 | Token may proceed |
| tok_handshake | output | 1 | A handshake packet should be sent |

## Verification
The bench builds the block with its default parameters: sixteen endpoints and an 8-bit data bus. With these values the 4-bit address reaches every endpoint, and every bus value reaches the unimplemented upper bits. Random writes, stall pulses, engine resets and tokens run across all sixteen endpoints, so collisions between a write, a stall pulse and an engine reset on the same endpoint happen often. Directed cases pin down the SETUP gating when bit 3 flips and the stall-over-clear priority.

// File: rtl/epctl_pkg.sv
package epctl_pkg;
   // field positions inside one endpoint register (decoded by the admission logic)
   localparam int FB_STALL = 0;
   localparam int FB_IN    = 1;
   localparam int FB_OUT   = 2;
   localparam int FB_NOCTL = 3;
   localparam int FB_HSK   = 4;
   localparam int FIELD_W  = 5;

   typedef logic [FIELD_W-1:0] ep_field_t;

   typedef enum logic [1:0] {
      TK_OUT   = 2'b00,
      TK_IN    = 2'b01,
      TK_SETUP = 2'b10,
      TK_RSVD  = 2'b11
   } tok_kind_e;
endpackage

// File: rtl/epctl_regfile.sv
module epctl_regfile
   import epctl_pkg::*;
#(
   parameter int NUM_EP = 16,
   parameter int ADDR_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sie_reset,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  ep_field_t               wr_field,
   input  logic                    stall_set,
   input  logic [ADDR_W-1:0]       stall_ep,
   output ep_field_t [NUM_EP-1:0]  regs
);
   for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
      logic      hit_wr;
      logic      hit_stall;
      ep_field_t q;
      ep_field_t d;

      assign hit_wr    = wr_en && (wr_addr == ADDR_W'(e));
      assign hit_stall = stall_set && (stall_ep == ADDR_W'(e));

      always_comb begin
         d = q;
         if (hit_wr)    d = wr_field;
         if (hit_stall) d[FB_STALL] = 1'b1;
         if (sie_reset) d[FB_STALL] = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end

      assign regs[e] = q;
   end
endmodule

// File: rtl/epctl_admit.sv
module epctl_admit
   import epctl_pkg::*;
#(
   parameter int NUM_EP = 16,
   parameter int ADDR_W = 4
) (
   input  ep_field_t [NUM_EP-1:0]  regs,
   input  logic                    tok_valid,
   input  logic [1:0]              tok_kind,
   input  logic [ADDR_W-1:0]       tok_ep,
   output logic                    accept,
   output logic                    handshake
);
   ep_field_t sel;
   logic      kind_ok;
   tok_kind_e kind;

   assign kind = tok_kind_e'(tok_kind);

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_EP; i++) begin
         if (tok_ep == ADDR_W'(i)) sel = regs[i];
      end
   end

   always_comb begin
      unique case (kind)
         TK_OUT:   kind_ok = sel[FB_OUT];
         TK_IN:    kind_ok = sel[FB_IN];
         TK_SETUP: kind_ok = sel[FB_OUT] && sel[FB_IN] && !sel[FB_NOCTL];
         default:  kind_ok = 1'b0;
      endcase
   end

   assign accept    = tok_valid && kind_ok;
   assign handshake = accept && sel[FB_HSK];
endmodule

// File: rtl/epctl_rdport.sv
module epctl_rdport
   import epctl_pkg::*;
#(
   parameter int NUM_EP = 16,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  ep_field_t [NUM_EP-1:0]  regs,
   input  logic [ADDR_W-1:0]       addr,
   output logic [DATA_W-1:0]       rdata
);
   ep_field_t sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_EP; i++) begin
         if (addr == ADDR_W'(i)) sel = regs[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= DATA_W'(sel);
   end
endmodule

// File: rtl/usb_ep_ctl_bank.sv
module usb_ep_ctl_bank
   import epctl_pkg::*;
#(
   parameter int NUM_EP = 16,
   parameter int DATA_W = 8,
   localparam int ADDR_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sie_reset,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_wr,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              stall_set,
   input  logic [ADDR_W-1:0] stall_ep,
   input  logic              tok_valid,
   input  logic [1:0]        tok_kind,
   input  logic [ADDR_W-1:0] tok_ep,
   output logic              tok_accept,
   output logic              tok_handshake
);
   if (NUM_EP < 1 || NUM_EP > 16) begin : g_bad_ep
      $error("usb_ep_ctl_bank: NUM_EP must be 1..16");
   end
   if (DATA_W < FIELD_W + 1) begin : g_bad_dw
      $error("usb_ep_ctl_bank: DATA_W too narrow for the field layout");
   end

   ep_field_t [NUM_EP-1:0] ep_regs;
   logic                   unused_wdata_hi;

   assign unused_wdata_hi = ^reg_wdata[DATA_W-1:FIELD_W];

   epctl_regfile #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .sie_reset (sie_reset),
      .wr_en     (reg_wr),
      .wr_addr   (reg_addr),
      .wr_field  (reg_wdata[FIELD_W-1:0]),
      .stall_set (stall_set),
      .stall_ep  (stall_ep),
      .regs      (ep_regs)
   );

   epctl_admit #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) i_admit (
      .regs      (ep_regs),
      .tok_valid (tok_valid),
      .tok_kind  (tok_kind),
      .tok_ep    (tok_ep),
      .accept    (tok_accept),
      .handshake (tok_handshake)
   );

   epctl_rdport #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .regs  (ep_regs),
      .addr  (reg_addr),
      .rdata (reg_rdata)
   );
endmodule

// File: rtl/epctl_chk.sv
module epctl_chk
   import epctl_pkg::*;
#(
   parameter int NUM_EP = 16,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   sie_reset,
   input logic [ADDR_W-1:0]      reg_addr,
   input logic [DATA_W-1:0]      reg_wdata,
   input logic                   reg_wr,
   input logic [DATA_W-1:0]      reg_rdata,
   input logic                   stall_set,
   input logic [ADDR_W-1:0]      stall_ep,
   input logic                   tok_valid,
   input logic                   tok_accept,
   input logic                   tok_handshake,
   input ep_field_t [NUM_EP-1:0] regs
);
   a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1:FIELD_W] == '0);

   a_r7_hsk_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
      tok_handshake |-> tok_accept);

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !tok_valid |-> (!tok_accept && !tok_handshake));

   a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> reg_rdata == DATA_W'($past(regs[reg_addr])));

   for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
      a_r9_stall_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (stall_set && stall_ep == ADDR_W'(e) && !sie_reset) |=> regs[e][FB_STALL]);

      a_r10_engine_clear: assert property (@(posedge clk) disable iff (!rst_n)
         sie_reset |=> !regs[e][FB_STALL]);

      a_r8_stall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (regs[e][FB_STALL] && !sie_reset &&
          !(reg_wr && reg_addr == ADDR_W'(e) && !reg_wdata[FB_STALL]))
         |=> regs[e][FB_STALL]);
   end
endmodule

bind usb_ep_ctl_bank epctl_chk #(.NUM_EP(NUM_EP), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sie_reset     (sie_reset),
   .reg_addr      (reg_addr),
   .reg_wdata     (reg_wdata),
   .reg_wr        (reg_wr),
   .reg_rdata     (reg_rdata),
   .stall_set     (stall_set),
   .stall_ep      (stall_ep),
   .tok_valid     (tok_valid),
   .tok_accept    (tok_accept),
   .tok_handshake (tok_handshake),
   .regs          (ep_regs)
);

// File: tb/test_usb_ep_ctl_bank.sv
module test_usb_ep_ctl_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NEP = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sie_reset = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_rdata;
   logic       stall_set = 1'b0;
   logic [3:0] stall_ep = '0;
   logic       tok_valid = 1'b0;
   logic [1:0] tok_kind = '0;
   logic [3:0] tok_ep = '0;
   logic       tok_accept;
   logic       tok_handshake;

   int total = 0;
   int bad = 0;
   logic [4:0] model [NEP];

   always #(CLK_PERIOD/2) clk = ~clk;

   usb_ep_ctl_bank i_usb_ep_ctl_bank (
      .clk(clk), .rst_n(rst_n), .sie_reset(sie_reset),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
      .stall_set(stall_set), .stall_ep(stall_ep),
      .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_ep(tok_ep),
      .tok_accept(tok_accept), .tok_handshake(tok_handshake)
   );

   function automatic logic f_accept(logic v, logic [1:0] k, logic [4:0] f);
      case (k)
         2'b00:   return v && f[2];
         2'b01:   return v && f[1];
         2'b10:   return v && f[2] && f[1] && !f[3];
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic f_hsk(logic v, logic [1:0] k, logic [4:0] f);
      return f_accept(v, k, f) && f[4];
   endfunction

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // one bus cycle, entered and left on a falling edge
   task automatic step(input logic wr, input logic [3:0] a, input logic [7:0] wd,
                       input logic ss, input logic [3:0] se, input logic sr,
                       input logic tv, input logic [1:0] tk, input logic [3:0] te);
      logic [7:0] exp_rd;
      logic       ea;
      logic       eh;
      reg_wr = wr; reg_addr = a; reg_wdata = wd;
      stall_set = ss; stall_ep = se; sie_reset = sr;
      tok_valid = tv; tok_kind = tk; tok_ep = te;
      #1;
      ea = f_accept(tv, tk, model[te]);
      eh = f_hsk(tv, tk, model[te]);
      // R4 R5 R6 R11 R12: same-cycle admission answer
      chk(tok_accept == ea, "R4/R5/R6/R11/R12 accept", int'(tok_accept), int'(ea));
      // R7: handshake
      chk(tok_handshake == eh, "R7 handshake", int'(tok_handshake), int'(eh));
      exp_rd = {3'b000, model[a]};
      @(posedge clk);
      for (int e = 0; e < NEP; e++) begin
         if (wr && a == 4'(e)) model[e] = wd[4:0];
         if (ss && se == 4'(e)) model[e][0] = 1'b1;
         if (sr) model[e][0] = 1'b0;
      end
      @(negedge clk);
      // R3 (and R2 R8 R9 R10 through stored values)
      chk(reg_rdata == exp_rd, "R3 readback", int'(reg_rdata), int'(exp_rd));
   endtask

   task automatic idle_rd(input logic [3:0] a);
      step(1'b0, a, 8'h00, 1'b0, 4'h0, 1'b0, 1'b0, 2'b00, 4'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED_0042);
      for (int e = 0; e < NEP; e++) model[e] = 5'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: every register reads zero after reset
      for (int e = 0; e < NEP; e++) begin
         idle_rd(4'(e));
         chk(reg_rdata == 8'h00, "R1 reset value", int'(reg_rdata), 0);
      end

      // R2: upper bits ignore writes
      step(1'b1, 4'd5, 8'hFF, 1'b0, 4'h0, 1'b0, 1'b0, 2'b00, 4'h0);
      idle_rd(4'd5);
      chk(reg_rdata == 8'h1F, "R2 upper bits", int'(reg_rdata), 8'h1F);

      // R6: SETUP gated by bit 3, IN/OUT still accepted
      step(1'b1, 4'd3, 8'h16, 1'b0, 4'h0, 1'b0, 1'b1, 2'b10, 4'd3);
      step(1'b0, 4'd3, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 2'b10, 4'd3);
      chk(tok_accept == 1'b1, "R6 setup open", int'(tok_accept), 1);
      step(1'b1, 4'd3, 8'h1E, 1'b0, 4'h0, 1'b0, 1'b1, 2'b10, 4'd3);
      step(1'b0, 4'd3, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 2'b10, 4'd3);
      step(1'b0, 4'd3, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 2'b01, 4'd3);
      step(1'b0, 4'd3, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 2'b00, 4'd3);
      step(1'b0, 4'd3, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 2'b11, 4'd3);

      // R8: stall pulse sets bit 0, sticky through a write keeping it
      step(1'b0, 4'd7, 8'h00, 1'b1, 4'd7, 1'b0, 1'b0, 2'b00, 4'h0);
      step(1'b1, 4'd7, 8'h13, 1'b0, 4'h0, 1'b0, 1'b0, 2'b00, 4'h0);
      idle_rd(4'd7);
      chk(reg_rdata == 8'h13, "R8 sticky stall", int'(reg_rdata), 8'h13);

      // R9: set beats same-cycle clearing write
      step(1'b1, 4'd7, 8'h12, 1'b1, 4'd7, 1'b0, 1'b0, 2'b00, 4'h0);
      idle_rd(4'd7);
      chk(reg_rdata == 8'h13, "R9 set wins", int'(reg_rdata), 8'h13);

      // R10: engine reset clears stall, keeps other bits
      step(1'b0, 4'd0, 8'h00, 1'b1, 4'd2, 1'b1, 1'b0, 2'b00, 4'h0);
      idle_rd(4'd7);
      chk(reg_rdata == 8'h12, "R10 engine reset", int'(reg_rdata), 8'h12);

      // R7: handshake off with bit 4 clear
      step(1'b1, 4'd9, 8'h06, 1'b0, 4'h0, 1'b0, 1'b0, 2'b00, 4'h0);
      step(1'b0, 4'd9, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 2'b00, 4'd9);
      chk(tok_handshake == 1'b0, "R7 no handshake", int'(tok_handshake), 0);

      // random mix over all endpoints
      for (int n = 0; n < 4000; n++) begin
         step(($urandom % 10) < 3, 4'($urandom), 8'($urandom),
              ($urandom % 10) == 0, 4'($urandom), ($urandom % 32) == 0,
              ($urandom % 5) != 0, 2'($urandom), 4'($urandom));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule